// File: doc/BRIEF.md
# Ping-Pong Snake Search-Pixel Buffer

This block holds search-area pixels for a full-search block matcher and hands them to the processing array in the order the array consumes them. It holds two identical banks. One bank is active and streams pixels. The other is idle and is loaded through an external write port with the search-area portion needed for the next motion vector. Each bank is arranged as `N-1` stream rows of `2P+N` pixels.

A single read pointer walks the active bank column by column, then row by row, wrapping after the last row. Every pixel it reads is written forward, one cycle later, into the same column of the following stream row, so the data snakes through the rows. While the pointer sits in the last `N-1` columns of a row (the boundary zone), a second read is issued in the same cycle from the start of the following row. The array can then work on boundary candidates and next-row candidates together.

When the last candidate of a search area is done, the requester raises a swap request. The banks exchange roles only if the idle bank holds a full load. Otherwise the swap is refused, a starvation flag is raised and streaming stays frozen.

Top module: `snkbuf_top`

## Requirements
- R1: After reset, bank 0 is active, and `a_vld`, `b_vld`, `fill_done`, `starve` and `swap_ack` are all low.
- R2: A write with `wr_en` high stores `wr_data` in the idle bank at linear address `wr_addr = row*(2P+N) + col`. A write whose address is at or beyond `(N-1)*(2P+N)` is dropped and not counted. `fill_done` rises once exactly `(N-1)*(2P+N)` in-range writes have landed since the last swap.
- R3: A swap request sampled while `fill_done` is high makes `swap_ack` high for one cycle and toggles `act_bank` at the same edge. Afterwards the read pointer restarts at row 0, column 0.
- R4: A swap request sampled while `fill_done` is low is refused. `starve` is high in the following cycle, `swap_ack` stays low and `act_bank` is unchanged.
- R5: A `step` sampled with no swap request reads the active bank at the pointer. In the next cycle `a_vld` is high, `a_data` holds the pixel and `a_sel` is the one-hot code of the row read. The pointer then moves to the next column, or to column 0 of the next row (row `N-2` wraps to row 0).
- R6: When the read column `c` is `2P+1` or higher, the same step also reads the next row at column `c-(2P+1)`. This drives `b_vld` high, `b_data` with that pixel and `b_sel` with the one-hot code of the next row. For lower columns `b_vld` is low and `b_sel` is zero.
- R7: The pixel read by port A from row `r`, column `c` is written into row `(r+1) mod (N-1)`, column `c` of the active bank on the following edge, so later passes read the forwarded values.
- R8: A `step` sampled while `swap_req` is high is ignored. No valid output appears and the pointer keeps its position for the next accepted step.
- R9: After a swap the former active bank becomes the write target and the fill count restarts from zero, so `fill_done` is low until a new full load arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | External pixel write strobe to the idle bank |
| wr_addr | input | AW | Linear address row*(2P+N)+col in the idle bank |
| wr_data | input | PW | Pixel to store |
| fill_done | output | 1 | Idle bank holds a full load |
| swap_req | input | 1 | Current search area finished; request bank exchange |
| swap_ack | output | 1 | Exchange took place at the last edge |
| starve | output | 1 | Last swap request was refused for an incomplete load |
| act_bank | output | 1 | Index of the streaming bank |
| step | input | 1 | Advance the read pointer by one pixel |
| a_data | output | PW | Primary stream pixel |
| a_vld | output | 1 | Primary pixel valid |
| a_sel | output | N-1 | One-hot stream row of the primary read |
| b_data | output | PW | Boundary (next-row) stream pixel |
| b_vld | output | 1 | Boundary pixel valid |
| b_sel | output | N-1 | One-hot stream row of the boundary read |

## Verification
The properties rely on the write strobe and the swap request not being sampled at the same edge. A write landing during an exchange would go to the bank that is just becoming active, and its count would be cleared. The stimulus therefore keeps `wr_en` low whenever `swap_req` is high. It also keeps `step` low during loads and exchanges, so each forwarded write is fully settled before the pointer restarts. All addresses the bench writes are in range, except one deliberately out-of-range write made while a load is incomplete.

// File: rtl/snkbuf_pkg.sv
package snkbuf_pkg;
    // Width for an index over v items, never below one bit.
    function automatic int sclog2(input int v);
        int w;
        w = $clog2(v);
        return (w < 1) ? 1 : w;
    endfunction
endpackage

// File: rtl/snkbuf_rdptr.sv
module snkbuf_rdptr #(
    parameter int ROWS = 3,
    parameter int RLEN = 8,
    parameter int HI   = 5,
    parameter int RW   = 2,
    parameter int CW   = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          adv,
    output logic [RW-1:0] row,
    output logic [CW-1:0] col,
    output logic [RW-1:0] row_nx,
    output logic [CW-1:0] col_b,
    output logic          bnd
);
    typedef struct packed {
        logic [RW-1:0] row;
        logic [CW-1:0] col;
    } ptr_t;

    ptr_t ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (clr) begin
            ptr_d = '0;
        end else if (adv) begin
            if (ptr_q.col == CW'(RLEN - 1)) begin
                ptr_d.col = '0;
                ptr_d.row = (ptr_q.row == RW'(ROWS - 1)) ? '0 : ptr_q.row + RW'(1);
            end else begin
                ptr_d.col = ptr_q.col + CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign row    = ptr_q.row;
    assign col    = ptr_q.col;
    assign row_nx = (ptr_q.row == RW'(ROWS - 1)) ? '0 : ptr_q.row + RW'(1);
    assign bnd    = (ptr_q.col >= CW'(HI));
    assign col_b  = ptr_q.col - CW'(HI);
endmodule

// File: rtl/snkbuf_bank.sv
module snkbuf_bank #(
    parameter int PW    = 8,
    parameter int DEPTH = 24,
    parameter int AW    = 5
) (
    input  logic          clk,
    input  logic          we_x,
    input  logic [AW-1:0] wa_x,
    input  logic [PW-1:0] wd_x,
    input  logic          we_f,
    input  logic [AW-1:0] wa_f,
    input  logic [PW-1:0] wd_f,
    input  logic [AW-1:0] ra_a,
    input  logic [AW-1:0] ra_b,
    output logic [PW-1:0] rd_a,
    output logic [PW-1:0] rd_b
);
    logic [PW-1:0] mem [DEPTH];

    // External and forward writes never target the same bank in one cycle.
    always_ff @(posedge clk) begin
        if (we_x) mem[wa_x] <= wd_x;
        if (we_f) mem[wa_f] <= wd_f;
    end

    assign rd_a = mem[ra_a];
    assign rd_b = mem[ra_b];
endmodule

// File: rtl/snkbuf_top.sv
module snkbuf_top #(
    parameter int  N    = 4,
    parameter int  P    = 2,
    parameter int  PW   = 8,
    localparam int ROWS = N - 1,
    localparam int RLEN = 2 * P + N,
    localparam int HI   = 2 * P + 1,
    localparam int BANK = ROWS * RLEN,
    localparam int AW   = snkbuf_pkg::sclog2(BANK),
    localparam int RW   = snkbuf_pkg::sclog2(ROWS),
    localparam int CW   = snkbuf_pkg::sclog2(RLEN),
    localparam int CNTW = snkbuf_pkg::sclog2(BANK + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [PW-1:0]   wr_data,
    output logic            fill_done,
    input  logic            swap_req,
    output logic            swap_ack,
    output logic            starve,
    output logic            act_bank,
    input  logic            step,
    output logic [PW-1:0]   a_data,
    output logic            a_vld,
    output logic [ROWS-1:0] a_sel,
    output logic [PW-1:0]   b_data,
    output logic            b_vld,
    output logic [ROWS-1:0] b_sel
);
    typedef struct packed {
        logic            act;
        logic [CNTW-1:0] cnt;
        logic            starve;
        logic            ack;
        logic [PW-1:0]   a_dat;
        logic [PW-1:0]   b_dat;
        logic            a_v;
        logic            b_v;
        logic [ROWS-1:0] a_sel;
        logic [ROWS-1:0] b_sel;
        logic            fe;
        logic [AW-1:0]   fa;
    } st_t;

    st_t st_d, st_q;

    logic [RW-1:0] row, row_nx;
    logic [CW-1:0] col, col_b;
    logic          bnd;
    logic          full, swap, go, ext_ok;
    logic [AW-1:0] ra_a, ra_b;
    logic [PW-1:0] rda [2];
    logic [PW-1:0] rdb [2];

    function automatic logic [AW-1:0] lin(input logic [RW-1:0] r, input logic [CW-1:0] c);
        return AW'(r) * AW'(RLEN) + AW'(c);
    endfunction

    snkbuf_rdptr #(.ROWS(ROWS), .RLEN(RLEN), .HI(HI), .RW(RW), .CW(CW)) u_ptr (
        .clk(clk), .rst_n(rst_n), .clr(swap), .adv(go),
        .row(row), .col(col), .row_nx(row_nx), .col_b(col_b), .bnd(bnd)
    );

    assign ra_a   = lin(row, col);
    assign ra_b   = lin(row_nx, col_b);
    assign ext_ok = wr_en && ({1'b0, wr_addr} < (AW + 1)'(BANK));

    for (genvar g = 0; g < 2; g++) begin : g_bank
        snkbuf_bank #(.PW(PW), .DEPTH(BANK), .AW(AW)) u_bank (
            .clk (clk),
            .we_x(ext_ok && (st_q.act != 1'(g))),
            .wa_x(wr_addr),
            .wd_x(wr_data),
            .we_f(st_q.fe && (st_q.act == 1'(g))),
            .wa_f(st_q.fa),
            .wd_f(st_q.a_dat),
            .ra_a(ra_a),
            .ra_b(ra_b),
            .rd_a(rda[g]),
            .rd_b(rdb[g])
        );
    end

    always_comb begin
        full = (st_q.cnt == CNTW'(BANK));
        swap = swap_req && full;
        go   = step && !swap_req;

        st_d        = st_q;
        st_d.ack    = swap;
        st_d.starve = swap_req && !full;
        if (swap) st_d.act = ~st_q.act;

        if (swap)                st_d.cnt = '0;
        else if (ext_ok && !full) st_d.cnt = st_q.cnt + CNTW'(1);

        st_d.a_v   = go;
        st_d.b_v   = go && bnd;
        st_d.a_sel = go ? (ROWS'(1) << row) : '0;
        st_d.b_sel = (go && bnd) ? (ROWS'(1) << row_nx) : '0;
        if (go)        st_d.a_dat = rda[st_q.act];
        if (go && bnd) st_d.b_dat = rdb[st_q.act];

        // Forward write lands one edge after the read it copies.
        st_d.fe = go;
        st_d.fa = lin(row_nx, col);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fill_done = full;
    assign swap_ack  = st_q.ack;
    assign starve    = st_q.starve;
    assign act_bank  = st_q.act;
    assign a_data    = st_q.a_dat;
    assign a_vld     = st_q.a_v;
    assign a_sel     = st_q.a_sel;
    assign b_data    = st_q.b_dat;
    assign b_vld     = st_q.b_v;
    assign b_sel     = st_q.b_sel;
endmodule

// File: rtl/snkbuf_chk.sv
module snkbuf_chk #(
    parameter int ROWS = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            fill_done,
    input logic            swap_ack,
    input logic            starve,
    input logic            act_bank,
    input logic            a_vld,
    input logic [ROWS-1:0] a_sel,
    input logic            b_vld,
    input logic [ROWS-1:0] b_sel
);
    // R5
    a_sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        a_vld |-> $countones(a_sel) == 1);

    // R5
    a_sel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !a_vld |-> a_sel == '0);

    // R6
    b_with_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        b_vld |-> a_vld && $countones(b_sel) == 1);

    // R3
    swap_needs_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        swap_ack |-> $past(fill_done));

    // R3
    bank_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act_bank) |-> swap_ack);

    // R4
    starve_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        starve |-> !swap_ack && !a_vld);

    // R8
    hold_on_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        swap_ack |-> !a_vld);

    // R9
    refill_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        swap_ack |-> !fill_done);
endmodule

bind snkbuf_top snkbuf_chk #(.ROWS(ROWS)) u_chk (
    .clk(clk), .rst_n(rst_n), .fill_done(fill_done), .swap_ack(swap_ack),
    .starve(starve), .act_bank(act_bank), .a_vld(a_vld), .a_sel(a_sel),
    .b_vld(b_vld), .b_sel(b_sel)
);

// File: tb/tb_snkbuf_top.sv
module tb_snkbuf_top;
    localparam int CLK_P = 10;
    localparam int N     = 4;
    localparam int P     = 2;
    localparam int PW    = 8;
    localparam int ROWS  = N - 1;
    localparam int RLEN  = 2 * P + N;
    localparam int HI    = 2 * P + 1;
    localparam int BANK  = ROWS * RLEN;
    localparam int AW    = snkbuf_pkg::sclog2(BANK);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            wr_en = 1'b0;
    logic [AW-1:0]   wr_addr = '0;
    logic [PW-1:0]   wr_data = '0;
    logic            fill_done, swap_ack, starve, act_bank;
    logic            swap_req = 1'b0;
    logic            step = 1'b0;
    logic [PW-1:0]   a_data, b_data;
    logic            a_vld, b_vld;
    logic [ROWS-1:0] a_sel, b_sel;

    int n_chk = 0;
    int n_bad = 0;
    int ref_m [2][BANK];
    int m_act = 0;
    int m_row = 0;
    int m_col = 0;

    always #(CLK_P / 2) clk = ~clk;

    snkbuf_top #(.N(N), .P(P), .PW(PW)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .fill_done(fill_done), .swap_req(swap_req), .swap_ack(swap_ack), .starve(starve),
        .act_bank(act_bank), .step(step), .a_data(a_data), .a_vld(a_vld), .a_sel(a_sel),
        .b_data(b_data), .b_vld(b_vld), .b_sel(b_sel)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        chk("R1", "act_bank", int'(act_bank), 0);
        chk("R1", "a_vld", int'(a_vld), 0);
        chk("R1", "b_vld", int'(b_vld), 0);
        chk("R1", "fill_done", int'(fill_done), 0);
        chk("R1", "starve", int'(starve), 0);
        chk("R1", "swap_ack", int'(swap_ack), 0);
    endtask

    // Loads addresses lo..hi-1 of the idle bank with a pattern.
    task automatic t_fill(input int seed, input int lo, input int hi);
        for (int i = lo; i < hi; i++) begin
            wr_en   = 1'b1;
            wr_addr = AW'(i);
            wr_data = PW'(seed + i * 7);
            ref_m[1 - m_act][i] = (seed + i * 7) & 8'hff;
            tick();
        end
        wr_en = 1'b0;
    endtask

    task automatic t_oor_write();
        wr_en   = 1'b1;
        wr_addr = AW'(BANK);
        wr_data = 8'h5a;
        tick();
        wr_en = 1'b0;
        chk("R2", "fill_done after out-of-range write", int'(fill_done), 0);
    endtask

    task automatic t_swap_ok();
        swap_req = 1'b1;
        tick();
        swap_req = 1'b0;
        m_act = 1 - m_act;
        m_row = 0;
        m_col = 0;
        chk("R3", "swap_ack", int'(swap_ack), 1);
        chk("R3", "act_bank", int'(act_bank), m_act);
        chk("R3", "starve", int'(starve), 0);
        chk("R9", "fill_done restarts", int'(fill_done), 0);
        tick();
        chk("R3", "swap_ack one cycle", int'(swap_ack), 0);
    endtask

    task automatic t_stream(input int k, input string tag);
        for (int s = 0; s < k; s++) begin
            int ea, eb, nr;
            bit bd;
            nr = (m_row == ROWS - 1) ? 0 : m_row + 1;
            bd = (m_col >= HI);
            ea = ref_m[m_act][m_row * RLEN + m_col];
            eb = bd ? ref_m[m_act][nr * RLEN + m_col - HI] : 0;
            step = 1'b1;
            tick();
            chk(tag, "a_vld", int'(a_vld), 1);
            chk(tag, "a_data", int'(a_data), ea);
            chk(tag, "a_sel", int'(a_sel), 1 << m_row);
            chk("R6", "b_vld", int'(b_vld), int'(bd));
            chk("R6", "b_sel", int'(b_sel), bd ? (1 << nr) : 0);
            if (bd) chk("R6", "b_data", int'(b_data), eb);
            ref_m[m_act][nr * RLEN + m_col] = ea;
            if (m_col == RLEN - 1) begin
                m_col = 0;
                m_row = nr;
            end else begin
                m_col++;
            end
        end
        step = 1'b0;
    endtask

    task automatic t_starve();
        swap_req = 1'b1;
        step     = 1'b1;
        tick();
        chk("R4", "starve", int'(starve), 1);
        chk("R4", "swap_ack", int'(swap_ack), 0);
        chk("R4", "act_bank", int'(act_bank), m_act);
        chk("R8", "a_vld while swap_req", int'(a_vld), 0);
        tick();
        chk("R4", "starve held", int'(starve), 1);
        chk("R8", "a_vld held off", int'(a_vld), 0);
        swap_req = 1'b0;
        step     = 1'b0;
        tick();
        chk("R4", "starve clears", int'(starve), 0);
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();

        t_fill(3, 0, BANK - 1);
        t_oor_write();
        t_fill(3, BANK - 1, BANK);
        chk("R2", "fill_done after full load", int'(fill_done), 1);
        t_swap_ok();

        t_stream(BANK, "R5");
        t_stream(BANK + 5, "R7");

        t_fill(40, 0, 6);
        t_starve();
        t_stream(4, "R8");

        t_fill(40, 6, BANK);
        chk("R9", "former active bank refilled", int'(fill_done), 1);
        t_swap_ok();
        t_stream(BANK + 2, "R9");

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(CLK_P * 100000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule